// File: doc/BRIEF.md
# Two-Bit-Per-Beat Non-Overlapping Pattern Detector

The block watches a serial bit stream that arrives two bits at a time, and it reports each time the five-bit pattern 1,0,0,1,0 ends in that stream. A strobe marks which cycles carry data. Cycles without the strobe are skipped: they add nothing to the stream and leave the search exactly where it was.

Matches never share bits. Once a match is reported, the search starts again from the very next bit, even when that bit sits in the same beat as the bit that ended the match. The pattern has an odd length, so a match can end on either bit position of a beat. Within an unfinished search, a mismatch does not throw away all progress. The search keeps the longest tail of the bits already seen that is still a valid start of the pattern.

Top module: `burst_pattern_detector`

## Requirements
- R1: Over the stream of accepted bits, `match_pulse` reports every non-overlapping occurrence of the pattern 1,0,0,1,0, where the first listed bit arrives first.
- R2: Within one accepted beat, `in_data[1]` is the earlier stream bit and `in_data[0]` the later one.
- R3: A cycle with `in_valid` low does not change the search progress, whatever `in_data` holds, and it produces no pulse on the following cycle.
- R4: `match_pulse` is registered. It is high for exactly the one cycle after the clock edge that accepts the beat completing an occurrence.
- R5: Bits consumed by a reported occurrence cannot begin or extend another one. For example, the stream 1001001001 gives one match at its fifth bit and a second at its eleventh bit when a 0 follows; it gives none at its eighth bit.
- R6: When an occurrence ends on `in_data[1]`, the `in_data[0]` bit of the same beat is treated as the first bit of a fresh search.
- R7: After a mismatch, partial progress falls back to the longest tail of the seen bits that is a start of the pattern. For example, the stream 110010 matches at its sixth bit.
- R8: A synchronous active-high `rst` clears the progress to no bits matched and drives `match_pulse` low.
- R9: At most one occurrence completes per beat, and `match_pulse` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_data` carries a beat |
| in_data | input | 2 | Two stream bits; bit 1 earlier, bit 0 later |
| match_pulse | output | 1 | One-cycle pulse after the beat that ends an occurrence |

## Verification
Two things can happen in the same beat: an occurrence completes on the earlier bit, and a fresh search starts on the later bit. A stream of two back-to-back patterns is shifted so that the first ends on `in_data[1]`. The second then only completes if the leftover bit was kept as the start of a new search, and the scoreboard checks that both pulses land. A stream with overlapping copies of the pattern is compared against a bit-serial reference that restarts after each hit, so a second pulse that reused bits fails the check. Valid gaps carrying data that would complete the pattern are placed inside these streams, and a long random stream with random gaps covers the remaining mixes.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  localparam int PAT_LEN = 5;
  localparam logic [PAT_LEN-1:0] PAT_BITS = 5'b10010; // MSB arrives first
  localparam int LANES = 2;
  localparam int PW = $clog2(PAT_LEN);

  typedef logic [PW-1:0] prog_t;

  typedef struct packed {
    logic  hit;
    prog_t nxt;
  } step_t;

  // pattern bit in arrival position idx (0 = first)
  function automatic logic pat_at(int idx);
    return PAT_BITS[PAT_LEN-1-idx];
  endfunction

  // one serial bit: extend progress, or fall back to the longest
  // tail of the seen bits that still begins the pattern
  function automatic step_t advance(prog_t cur, logic b);
    logic [PAT_LEN-1:0] seen;
    int   best;
    logic ok;
    step_t r;
    for (int j = 0; j < PAT_LEN; j++) begin
      if (j < int'(cur))       seen[j] = pat_at(j);
      else if (j == int'(cur)) seen[j] = b;
      else                     seen[j] = 1'b0;
    end
    best = 0;
    for (int k = 1; k <= PAT_LEN; k++) begin
      if (k <= int'(cur) + 1) begin
        ok = 1'b1;
        for (int m = 0; m < PAT_LEN; m++) begin
          if (m < k) begin
            if (seen[int'(cur) + 1 - k + m] != pat_at(m)) ok = 1'b0;
          end
        end
        if (ok) best = k;
      end
    end
    r.hit = (best == PAT_LEN);
    r.nxt = r.hit ? '0 : prog_t'(best);
    return r;
  endfunction
endpackage

// File: rtl/seqdet_step.sv
module seqdet_step
  import seqdet_pkg::*;
(
  input  prog_t cur,
  input  logic  bit_in,
  output prog_t nxt,
  output logic  hit
);
  step_t res;

  always_comb begin
    res = advance(cur, bit_in);
    nxt = res.nxt;
    hit = res.hit;
  end
endmodule

// File: rtl/seqdet_chain.sv
module seqdet_chain
  import seqdet_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  prog_t              start,
  input  logic [N_LANES-1:0] beat,
  output prog_t              final_p,
  output logic [N_LANES-1:0] lane_hit
);
  prog_t stage [N_LANES+1];

  assign stage[0] = start;

  // lane i handles the i-th bit in arrival order (beat MSB first)
  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    seqdet_step u_step (
      .cur    (stage[i]),
      .bit_in (beat[N_LANES-1-i]),
      .nxt    (stage[i+1]),
      .hit    (lane_hit[i])
    );
  end

  assign final_p = stage[N_LANES];
endmodule

// File: rtl/burst_pattern_detector.sv
module burst_pattern_detector
  import seqdet_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [LANES-1:0] in_data,
  output logic             match_pulse
);
  prog_t            prog;
  prog_t            prog_next;
  logic [LANES-1:0] lane_hit;

  seqdet_chain #(.N_LANES(LANES)) u_chain (
    .start    (prog),
    .beat     (in_data),
    .final_p  (prog_next),
    .lane_hit (lane_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prog        <= '0;
      match_pulse <= 1'b0;
    end else begin
      match_pulse <= in_valid && (|lane_hit);
      if (in_valid) prog <= prog_next;
    end
  end

  p_prog_range_r1: assert property (@(posedge clk) disable iff (rst)
    int'(prog) < PAT_LEN);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(prog));

  p_pulse_needs_beat_r3: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> $past(in_valid));

  p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst)
    match_pulse |=> !match_pulse);

  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_hit[LANES-1]) |=> (prog == '0));

  p_one_hit_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_hit));
endmodule

// File: tb/burst_pattern_detector_test.sv
module burst_pattern_detector_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] PATTERN = 5'b10010;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_data = 2'b00;
  logic       match_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int    due;
    logic  exp;
    string tag;
  } item_t;
  item_t sb[$];
  bit    hist[$];

  burst_pattern_detector uut (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .match_pulse (match_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // bit-serial reference: naive window compare, cleared after each hit
  function automatic bit ref_bit(bit b);
    bit hit;
    hist.push_back(b);
    hit = 1'b0;
    if (hist.size() >= 5) begin
      hit = 1'b1;
      for (int i = 0; i < 5; i++)
        if (hist[hist.size()-5+i] != PATTERN[4-i]) hit = 1'b0;
    end
    if (hit) hist.delete();
    else if (hist.size() > 4) void'(hist.pop_front());
    return hit;
  endfunction

  task automatic beat(input bit v, input logic [1:0] d, input string tag);
    item_t it;
    bit h;
    @(posedge clk);
    #1;
    in_valid = v;
    in_data  = d;
    h = 1'b0;
    if (v) begin
      for (int i = 1; i >= 0; i--) h = ref_bit(d[i]) | h;
    end
    it.due = cyc + 1;
    it.exp = h;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic stream(input logic [31:0] bits, input int n, input bit gaps,
                        input string tag);
    for (int i = n - 2; i >= 0; i -= 2) begin
      beat(1'b1, bits[i +: 2], tag);
      if (gaps) beat(1'b0, 2'b00, tag);
    end
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1;
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    hist.delete();
  endtask

  // monitor: pop the item due this cycle and compare
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (match_pulse !== it.exp) begin
        errors++;
        $display("FAIL %s (R4 timing): match_pulse=%0b expected %0b at cycle %0d",
                 it.tag, match_pulse, it.exp, cyc);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (match_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset: match_pulse=%0b expected 0", match_pulse);
    end

    stream(32'b10010000, 8, 1'b0, "R1 R4 end on bit1");
    stream(32'b01001000, 8, 1'b0, "R2 end on bit0");
    stream(32'b011001, 6, 1'b0, "R2 reversed beat order");
    stream(32'b100101001000, 12, 1'b0, "R6 restart inside beat");
    stream(32'b100100100100, 12, 1'b0, "R5 no overlap");
    stream(32'b11001000, 8, 1'b0, "R7 fallback");
    stream(32'b100101001000, 12, 1'b1, "R3 gaps");
    // R3: idle beat whose data would complete the pattern
    beat(1'b1, 2'b10, "R3 idle complete");
    beat(1'b1, 2'b01, "R3 idle complete");
    beat(1'b0, 2'b00, "R3 idle complete");
    beat(1'b0, 2'b01, "R3 idle complete");
    beat(1'b1, 2'b01, "R3 idle complete");
    beat(1'b1, 2'b11, "R3 idle complete");
    beat(1'b0, 2'b00, "R3 idle complete");

    // R8: progress held before reset must be gone after it
    beat(1'b1, 2'b10, "R8 pre-reset");
    beat(1'b1, 2'b01, "R8 pre-reset");
    beat(1'b0, 2'b00, "R8 pre-reset");
    do_reset();
    beat(1'b1, 2'b00, "R8 progress cleared");
    beat(1'b1, 2'b00, "R8 progress cleared");
    beat(1'b0, 2'b00, "R8 progress cleared");

    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        beat(lfsr[3] | lfsr[7], lfsr[1:0], "R9 random stream");
      end
    end
    beat(1'b0, 2'b00, "R9 drain");
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule